// File: doc/BRIEF.md
# Multi-Setup Conversion Readout Port

This block is the serial slave for the digital side of a multi-channel converter while results are being read out. A host clocks a command byte in on `sdi` with the serial clock `sclk`. The command names a setup pointer and chooses one of two patterns. The block can convert that single setup, or it can sweep every setup from 0 up to the pointer. A stub converter produces one 24-bit result per referenced setup. The results collect in a 16-entry data FIFO, and `sdo` is pulled low once the whole set is queued.

The host then clocks a readout frame. The first eight clocks only clear the ready flag, and `sdo` stays low during them. After them the port sends 24 bits for each queued result, MSB first, in the order the setups were converted. When continuous mode is set, the byte the host places on `sdi` during the eight flag clocks decides what follows the frame. The port either converts the same set again or drains the data and returns to command mode. `sclk` and `sdi` are oversampled on the system clock `clk`.

States: `S_CMD` collects the command byte. `S_CONV` runs the stub once per referenced setup. `S_FLAG` counts the eight flag clocks with `sdo` low. `S_DATA` shifts out the result words. The transitions are as follows. `S_CMD`→`S_CONV` on an accepted command byte. `S_CONV`→`S_FLAG` when the last setup's result is queued. `S_FLAG`→`S_DATA` on the falling edge after the eighth flag clock. `S_DATA`→`S_CONV` (continue) or `S_DATA`→`S_CMD` (exit) on the falling edge after the last data bit.

Top module: `mscan_readout`

## Requirements
- R1: A command byte is shifted in MSB first on `sclk` rising edges. Bit 7 must be 1 and bit 0 must be 0 for the byte to be accepted. Bits 6:3 form the setup pointer, bit 2 selects sweep, and bit 1 selects continuous mode. Any other byte is dropped: the port stays in command mode with `sdo` high and accepts the next byte.
- R2: Without sweep, only the setup named by the pointer is converted (pointer 1110 is setup 14, the fifteenth). With sweep, setups 0 through the pointer are converted in ascending order.
- R3: `sdo` is high in command mode and during conversion. It falls only once the result of every referenced setup is queued.
- R4: Each readout frame begins with eight flag clocks during which `sdo` stays low and carries no result data.
- R5: After the flag field the port sends exactly 24 bits per referenced setup, MSB first, in conversion order. `sdo` changes after `sclk` falling edges and is valid at the following rising edge.
- R6: The result for setup s in round r is {s[3:0], 4'hC, r[7:0], 8'h5A ^ {4'h0, s[3:0]}}. The round is 0 for the first set after a command and rises by one for each continued set.
- R7: In continuous mode, a flag byte other than 8'hFF makes the port convert the same setups again after the frame. This includes 8'h00 and any mixed value.
- R8: In continuous mode, flag byte 8'hFF makes the port read out the remaining data, then return to command mode with no further conversion.
- R9: Without continuous mode, the flag byte is ignored. A single-setup single-shot readout takes 32 clocks, after which the port is in command mode.
- R10: The 16-entry FIFO never overflows or underflows, and it is empty whenever the port is in command mode. A full 16-setup sweep fits.
- R11: `sclk` and `sdi` activity during conversion is ignored.
- R12: `sdo` returns high after the falling edge that ends the last data bit of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on `sclk` rising edges |
| sdo | output | 1 | Ready flag and serial data out, updated after `sclk` falling edges |

## Verification
The pins are synchronised through two flops, so a serial edge takes effect two to three `clk` cycles after the bench drives it. Each serial half period is four `clk` cycles long. The bench therefore reads `sdo` on the last `clk` cycle before it raises `sclk`, which leaves room after the update triggered by the falling edge. After the eighth command clock, the ready fall is due after 64 `clk` cycles per referenced setup plus a few cycles of pipeline. The bench polls for it within a bounded window. Expected words go into a scoreboard queue when a set is issued or continued, and they are popped as each 24-bit word completes on `sdo`.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

    localparam int SETUP_W   = 4;
    localparam int WORD_W    = 24;
    localparam int ROUND_W   = 8;
    localparam int CMD_BITS  = 8;
    localparam int FLAG_BITS = 8;
    localparam int CNT_W     = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        S_CMD  = 2'd0,
        S_CONV = 2'd1,
        S_FLAG = 2'd2,
        S_DATA = 2'd3
    } port_state_t;

    // Synthetic conversion value produced by the stub converter.
    function automatic logic [WORD_W-1:0] mk_result(
        input logic [SETUP_W-1:0] setup,
        input logic [ROUND_W-1:0] round
    );
        return {setup, 4'hC, round, 8'h5A ^ {4'h0, setup}};
    endfunction

endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic sdi_s
);
    logic sclk_m, sclk_s, sclk_d;
    logic sdi_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_m <= 1'b0;
            sclk_s <= 1'b0;
            sclk_d <= 1'b0;
            sdi_m  <= 1'b0;
            sdi_s  <= 1'b0;
        end else begin
            sclk_m <= sclk;
            sclk_s <= sclk_m;
            sclk_d <= sclk_s;
            sdi_m  <= sdi;
            sdi_s  <= sdi_m;
        end
    end

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             underflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            underflow <= 1'b0;
        end else if (clr) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            underflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            if (pop && empty) underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/conv_stub.sv
module conv_stub
    import mscan_pkg::*;
#(
    parameter int CONV_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SETUP_W-1:0] setup,
    input  logic [ROUND_W-1:0] round,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  result
);
    localparam int TMR_W = $clog2(CONV_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_END = TMR_W'(CONV_CYC - 1);

    logic [TMR_W-1:0]   tmr;
    logic [SETUP_W-1:0] setup_q;
    logic [ROUND_W-1:0] round_q;

    assign done   = busy && (tmr == TMR_END);
    assign result = mk_result(setup_q, round_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tmr     <= '0;
            setup_q <= '0;
            round_q <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            tmr     <= '0;
            setup_q <= setup;
            round_q <= round;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            tmr <= tmr + 1'b1;
        end
    end

endmodule

// File: rtl/mscan_readout.sv
module mscan_readout
    import mscan_pkg::*;
#(
    parameter int CONV_CYC   = 64,
    parameter int FIFO_DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    port_state_t state, nstate;

    logic rise_evt, fall_evt, sdi_s;

    logic [CNT_W-1:0]    bitcnt;
    logic [CMD_BITS-1:0] cmd_sr;
    logic [FLAG_BITS-1:0] flag_sr;
    logic [SETUP_W-1:0]  ptr, cur, wordcnt;
    logic                sweep, cont, quit;
    logic [ROUND_W-1:0]  round;
    logic [WORD_W-1:0]   data_sr;

    logic                stub_start, stub_busy, stub_done;
    logic [WORD_W-1:0]   stub_result;

    logic                fifo_push, fifo_pop, fifo_clr;
    logic                fifo_empty, fifo_full, fifo_underflow;
    logic [WORD_W-1:0]   fifo_dout;

    logic [CMD_BITS-1:0] cmd_byte;
    logic                cmd_done, cmd_ok;
    logic                conv_fin, flag_end, word_end, frame_end;
    logic [SETUP_W-1:0]  first_setup, span;

    sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .rise  (rise_evt),
        .fall  (fall_evt),
        .sdi_s (sdi_s)
    );

    conv_stub #(.CONV_CYC(CONV_CYC)) u_stub (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (stub_start),
        .setup  (cur),
        .round  (round),
        .busy   (stub_busy),
        .done   (stub_done),
        .result (stub_result)
    );

    result_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (fifo_push),
        .din       (stub_result),
        .pop       (fifo_pop),
        .dout      (fifo_dout),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .underflow (fifo_underflow)
    );

    // Event decode
    assign cmd_byte    = {cmd_sr[CMD_BITS-2:0], sdi_s};
    assign cmd_ok      = cmd_byte[7] & ~cmd_byte[0];
    assign cmd_done    = (state == S_CMD) && rise_evt && (bitcnt == CNT_W'(CMD_BITS - 1));
    assign first_setup = sweep ? '0 : ptr;
    assign span        = ptr - first_setup;
    assign conv_fin    = (state == S_CONV) && stub_done && (cur == ptr);
    assign flag_end    = (state == S_FLAG) && fall_evt && (bitcnt == CNT_W'(FLAG_BITS));
    assign word_end    = (state == S_DATA) && fall_evt && (bitcnt == CNT_W'(WORD_W));
    assign frame_end   = word_end && (wordcnt == span);

    assign stub_start  = (state == S_CONV) && !stub_busy;
    assign fifo_push   = (state == S_CONV) && stub_done;
    assign fifo_pop    = flag_end || (word_end && !frame_end);
    assign fifo_clr    = (state == S_CMD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CMD;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_CMD:  if (cmd_done && cmd_ok) nstate = S_CONV;
            S_CONV: if (conv_fin)           nstate = S_FLAG;
            S_FLAG: if (flag_end)           nstate = S_DATA;
            S_DATA: if (frame_end)          nstate = quit ? S_CMD : S_CONV;
            default:                        nstate = S_CMD;
        endcase
    end

    // Sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            cmd_sr  <= '0;
            flag_sr <= '0;
            ptr     <= '0;
            sweep   <= 1'b0;
            cont    <= 1'b0;
            quit    <= 1'b0;
            cur     <= '0;
            wordcnt <= '0;
            round   <= '0;
            data_sr <= '0;
        end else begin
            unique case (state)
                S_CMD: begin
                    if (rise_evt) begin
                        cmd_sr <= cmd_byte;
                        bitcnt <= cmd_done ? '0 : bitcnt + 1'b1;
                    end
                    if (cmd_done && cmd_ok) begin
                        ptr   <= cmd_byte[6:3];
                        sweep <= cmd_byte[2];
                        cont  <= cmd_byte[1];
                        cur   <= cmd_byte[2] ? '0 : cmd_byte[6:3];
                        round <= '0;
                    end
                end
                S_CONV: begin
                    bitcnt <= '0;
                    if (stub_done && !conv_fin) cur <= cur + 1'b1;
                end
                S_FLAG: begin
                    if (rise_evt && bitcnt < CNT_W'(FLAG_BITS)) begin
                        flag_sr <= {flag_sr[FLAG_BITS-2:0], sdi_s};
                        bitcnt  <= bitcnt + 1'b1;
                    end
                    if (flag_end) begin
                        quit    <= !cont || (flag_sr == '1);
                        data_sr <= fifo_dout;
                        bitcnt  <= '0;
                        wordcnt <= '0;
                    end
                end
                S_DATA: begin
                    if (rise_evt && bitcnt < CNT_W'(WORD_W)) bitcnt <= bitcnt + 1'b1;
                    if (fall_evt) begin
                        if (frame_end) begin
                            bitcnt <= '0;
                            if (!quit) begin
                                round <= round + 1'b1;
                                cur   <= first_setup;
                            end
                        end else if (word_end) begin
                            data_sr <= fifo_dout;
                            bitcnt  <= '0;
                            wordcnt <= wordcnt + 1'b1;
                        end else begin
                            data_sr <= {data_sr[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                default: bitcnt <= '0;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo <= 1'b1;
        end else begin
            unique case (state)
                S_CMD:  sdo <= 1'b1;
                S_CONV: sdo <= conv_fin ? 1'b0 : 1'b1;
                S_FLAG: sdo <= flag_end ? fifo_dout[WORD_W-1] : 1'b0;
                S_DATA: begin
                    if (frame_end)     sdo <= 1'b1;
                    else if (word_end) sdo <= fifo_dout[WORD_W-1];
                    else if (fall_evt) sdo <= data_sr[WORD_W-2];
                end
                default: sdo <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/mscan_readout_chk.sv
module mscan_readout_chk
    import mscan_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input port_state_t state,
    input logic        sdo,
    input logic        fall_evt,
    input logic        fifo_push,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        fifo_underflow
);
    p_sdo_high_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD) |-> sdo);

    p_sdo_high_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONV) |-> sdo);

    p_flag_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLAG) |-> !sdo);

    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !fall_evt) |=> $stable(sdo));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_underflow);

    p_empty_in_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD) |-> fifo_empty);

endmodule

bind mscan_readout mscan_readout_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .sdo            (sdo),
    .fall_evt       (fall_evt),
    .fifo_push      (fifo_push),
    .fifo_full      (fifo_full),
    .fifo_empty     (fifo_empty),
    .fifo_underflow (fifo_underflow)
);

// File: tb/mscan_readout_tb.sv
module mscan_readout_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 4;
    localparam int CONV_CYC   = 64;
    localparam int READY_WAIT = 16 * CONV_CYC + 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [23:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mscan_readout #(.CONV_CYC(CONV_CYC), .FIFO_DEPTH(16)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .sdo   (sdo)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] word_of(input int s, input int r);
        logic [3:0] s4 = 4'(s);
        logic [7:0] r8 = 8'(r);
        return {s4, 4'hC, r8, 8'h5A ^ {4'h0, s4}};
    endfunction

    // Driver side of the scoreboard
    task automatic queue_set(input int first, input int last, input int r);
        for (int s = first; s <= last; s++) exp_q.push_back(word_of(s, r));
    endtask

    task automatic sclk_cycle(input logic din, output logic seen);
        sdi = din;
        repeat (HALF_CLKS) @(negedge clk);
        seen = sdo;
        sclk = 1'b1;
        repeat (HALF_CLKS) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic seen;
        for (int i = 7; i >= 0; i--) sclk_cycle(b[i], seen);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (sdo !== 1'b0 && n < READY_WAIT) begin
            @(negedge clk);
            n++;
        end
        check(sdo === 1'b0, req, {31'b0, sdo}, 32'h0);
    endtask

    task automatic hold_high(input int cycles, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sdo !== 1'b1) ok = 1'b0;
        end
        check(ok, req, {31'b0, ok}, 32'h1);
    endtask

    // Monitor side: assemble words from sdo and compare against the queue
    task automatic readout(input logic [7:0] flag, input int nwords);
        logic seen;
        logic [23:0] got;
        logic [23:0] exp;
        bit flag_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sclk_cycle(flag[i], seen);
            if (seen !== 1'b0) flag_ok = 1'b0;
        end
        check(flag_ok, "R4 flag field low", {31'b0, flag_ok}, 32'h1);
        for (int w = 0; w < nwords; w++) begin
            for (int b = 23; b >= 0; b--) begin
                sclk_cycle(1'b0, seen);
                got[b] = seen;
            end
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 24'hxxxxxx;
            check(got === exp, "R5 R6 data word", {8'h0, got}, {8'h0, exp});
        end
        repeat (HALF_CLKS) @(negedge clk);
        check(sdo === 1'b1, "R12 sdo high after frame", {31'b0, sdo}, 32'h1);
    endtask

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo === 1'b1, "R3 reset sdo high", {31'b0, sdo}, 32'h1);

        // R2 R9: single shot, pointer 1110 (setup 14); flag content ignored
        queue_set(14, 14, 0);
        send_byte(8'hF0);
        hold_high(CONV_CYC / 2, "R3 sdo high while converting");
        wait_ready("R3 ready fall single");
        readout(8'h00, 1);
        hold_high(4 * CONV_CYC, "R9 no reconversion after single shot");

        // R2: sweep setups 0..3 single shot
        queue_set(0, 3, 0);
        send_byte(8'h9C);
        wait_ready("R3 ready fall sweep");
        readout(8'hFF, 4);
        hold_high(2 * CONV_CYC, "R9 command mode after sweep");

        // R7 R8: continuous on setup 3, rounds 0,1,2
        queue_set(3, 3, 0);
        send_byte(8'h9A);
        wait_ready("R7 ready round0");
        queue_set(3, 3, 1);
        readout(8'h00, 1);
        wait_ready("R7 ready after 00");
        queue_set(3, 3, 2);
        readout(8'h5A, 1);
        wait_ready("R7 ready after mixed byte");
        readout(8'hFF, 1);
        hold_high(4 * CONV_CYC, "R8 exit to command mode");

        // R10: continuous sweep over all 16 setups, fills the FIFO
        queue_set(0, 15, 0);
        send_byte(8'hFE);
        wait_ready("R10 ready full sweep");
        queue_set(0, 15, 1);
        readout(8'h00, 16);
        wait_ready("R10 ready second full sweep");
        readout(8'hFF, 16);
        check(exp_q.size() == 0, "R10 all results drained", 32'(exp_q.size()), 32'h0);

        // R1: rejected bytes (bit7 clear, then bit0 set)
        send_byte(8'h7E);
        hold_high(4 * CONV_CYC, "R1 byte with bit7 clear ignored");
        send_byte(8'hA9);
        hold_high(4 * CONV_CYC, "R1 byte with bit0 set ignored");

        // R11: serial activity during conversion is ignored
        queue_set(5, 5, 0);
        send_byte(8'hA8);
        for (int i = 0; i < 3; i++) sclk_cycle(1'b1, seen);
        wait_ready("R11 ready despite clocks");
        readout(8'h00, 1);
        check(exp_q.size() == 0, "R11 scoreboard empty", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule